// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDIO bus. Software sees two 32-bit registers on a simple write/read bus. One is a command register that packs a start/busy flag, a direction bit and two 5-bit address fields. The other is a 16-bit data register. For a write, software first loads the value into the data register. It then writes the command word with bit 0 set.

The block then drives MDC from a divided system clock and shifts out a 64-bit management frame. On a read, it releases MDIO for turnaround and data and collects the PHY's 16 bits. Bit 0 of the command register stays at 1 for the whole frame. Software polls that bit as its completion handshake. After a read, the data register holds the value returned by the PHY.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Writing the command register with bit 0 = 1 while idle starts a frame. Bit 0 reads back as 1 from the next cycle until the frame ends, then reads as 0.
- R2: Command bit 1 selects the direction: 1 sends opcode 01 (write), 0 sends opcode 10 (read).
- R3: A frame is 64 MDC periods, sent MSB first. It consists of 32 ones, start pattern 01, the opcode, the PHY address (command bits 16:12), the register address (command bits 8:4), turnaround, then 16 data bits. On a write, the turnaround is 10 and the data bits come from the data register.
- R4: On a read, the output enable is low for the last 18 bits (turnaround and data). MDIO is sampled on each rising MDC edge of the data bits. When bit 0 clears, the data register (offset 0x4C) holds the 16 sampled bits, the first one sampled as bit 15.
- R5: MDC is low while idle. During a frame, each MDC half-period lasts `mdc_half_div` system clocks, and a setting of 0 counts as 1. The MDIO output changes only together with a falling MDC edge.
- R6: A command write that arrives while busy is ignored. The stored fields keep their values, and no second frame follows.
- R7: A write to the data register while busy is ignored, and the register keeps its value.
- R8: The command register (offset 0x48) reads back the PHY address in bits 16:12, the register address in bits 8:4, the direction in bit 1 and busy in bit 0. All other bits read as 0. A command write with bit 0 = 0 stores the fields and starts nothing.
- R9: After reset, both registers read 0, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_half_div | input | DIV_W | System clocks per MDC half-period (0 treated as 1) |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | ADDR_W | Register write byte address |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | ADDR_W | Register read byte address |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bound checker checks several properties on every cycle. MDC is low and the output enable is off whenever no frame runs. The MDIO output moves only on falling MDC edges. The stored command fields and the data register hold still for the whole duration of a frame. Only the bench scenarios can show the rest. These are the bit content of whole frames, the captured read value, the MDC half-period length for a given divider setting, and the fact that a mid-frame command or data write leaves no trace once the frame ends.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_START   = 46;
  localparam int DATA_START = 48;
  localparam int DATA_W     = 16;
  localparam int FLD_W      = 5;

  localparam int CMD_BUSY_BIT = 0;
  localparam int CMD_DIR_BIT  = 1;
  localparam int CMD_REG_LSB  = 4;
  localparam int CMD_PHY_LSB  = 12;

  localparam logic [1:0] SOF_PAT  = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;
  localparam logic [1:0] TA_FLOAT = 2'b11;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;
  logic             term;

  assign limit  = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
  assign term   = en_i && (cnt_q == limit - DIV_W'(1));
  assign rise_o = term && !mdc_o;
  assign fall_o = term && mdc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [FLD_W-1:0]  phy_i,
  input  logic [FLD_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [BIT_W-1:0]      bit_q;
  logic                  run_q;
  logic                  wr_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  last_bit;

  assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign done_o   = run_q && fall_i && last_bit;
  assign busy_o   = run_q;
  assign mdio_o   = run_q ? tx_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = run_q && (wr_q || (bit_q < BIT_W'(TA_START)));
  assign rdata_o  = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      bit_q <= '0;
      run_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (start_i && !run_q) begin
      tx_q  <= {{PRE_BITS{1'b1}}, SOF_PAT, (write_i ? OP_WRITE : OP_READ),
                phy_i, reg_i, (write_i ? TA_DRIVE : TA_FLOAT), wdata_i};
      bit_q <= '0;
      run_q <= 1'b1;
      wr_q  <= write_i;
    end else if (run_q && fall_i) begin
      if (last_bit) begin
        run_q <= 1'b0;
      end else begin
        bit_q <= bit_q + BIT_W'(1);
        tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (run_q && rise_i && (bit_q >= BIT_W'(DATA_START))) begin
      rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int CMD_OFS  = 'h48,
  parameter int DATA_OFS = 'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  mdc_half_div,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic [FLD_W-1:0]  cmd_phy_q;
  logic [FLD_W-1:0]  cmd_reg_q;
  logic              cmd_dir_q;
  logic [DATA_W-1:0] data_q;
  logic              busy;
  logic              done;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] rx_val;
  logic              cmd_wr;
  logic              data_wr;
  logic              launch;
  logic [31:0]       cmd_word;

  assign cmd_wr  = bus_wr && (bus_waddr == CMD_A) && !busy;
  assign data_wr = bus_wr && (bus_waddr == DATA_A) && !busy;
  assign launch  = cmd_wr && bus_wdata[CMD_BUSY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_phy_q <= '0;
      cmd_reg_q <= '0;
      cmd_dir_q <= 1'b0;
    end else if (cmd_wr) begin
      cmd_phy_q <= bus_wdata[CMD_PHY_LSB +: FLD_W];
      cmd_reg_q <= bus_wdata[CMD_REG_LSB +: FLD_W];
      cmd_dir_q <= bus_wdata[CMD_DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= bus_wdata[DATA_W-1:0];
    end else if (done && !cmd_dir_q) begin
      data_q <= rx_val;
    end
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_PHY_LSB +: FLD_W] = cmd_phy_q;
    cmd_word[CMD_REG_LSB +: FLD_W] = cmd_reg_q;
    cmd_word[CMD_DIR_BIT]          = cmd_dir_q;
    cmd_word[CMD_BUSY_BIT]         = busy;
  end

  always_comb begin
    if (bus_raddr == CMD_A)       bus_rdata = cmd_word;
    else if (bus_raddr == DATA_A) bus_rdata = {{(32-DATA_W){1'b0}}, data_q};
    else                          bus_rdata = '0;
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (busy),
    .half_div_i (mdc_half_div),
    .mdc_o      (mdc),
    .rise_o     (rise_stb),
    .fall_o     (fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (launch),
    .write_i (bus_wdata[CMD_DIR_BIT]),
    .phy_i   (bus_wdata[CMD_PHY_LSB +: FLD_W]),
    .reg_i   (bus_wdata[CMD_REG_LSB +: FLD_W]),
    .wdata_i (data_q),
    .rise_i  (rise_stb),
    .fall_i  (fall_stb),
    .mdio_i  (mdio_i),
    .busy_o  (busy),
    .done_o  (done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rdata_o (rx_val)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [4:0]  cmd_phy,
  input logic [4:0]  cmd_reg,
  input logic [15:0] data
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R9

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_phy) && $stable(cmd_reg))); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data)); // R7
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .cmd_phy (cmd_phy_q),
  .cmd_reg (cmd_reg_q),
  .data    (data_q)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam logic [7:0] CMD_A  = 8'h48;
  localparam logic [7:0] DATA_A = 8'h4C;
  // {write, phy[4:0], reg[4:0], data[15:0], half_div[3:0]}
  localparam int NV = 4;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 5'h01, 5'h00, 16'hA5C3, 4'd2},
    {1'b0, 5'h1F, 5'h02, 16'h7961, 4'd1},
    {1'b1, 5'h10, 5'h1F, 16'h0001, 4'd4},
    {1'b0, 5'h00, 5'h11, 16'hFFFE, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] phy_val = '0;
  int phy_n = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .mdc_half_div(half_div),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    cap_o  <= {cap_o[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
  end

  always @(negedge mdc) begin
    phy_n = phy_n + 1;
    mdio_i = (phy_n >= 48 && phy_n <= 63) ? phy_val[63 - phy_n] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] r;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_read(CMD_A, r);
      if (!r[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] cmd_word(input bit w, input logic [4:0] p, input logic [4:0] r);
    return (32'(p) << 12) | (32'(r) << 4) | (32'(w) << 1) | 32'd1;
  endfunction

  function automatic logic [63:0] exp_frame(input bit w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b11), d};
  endfunction

  task automatic run_frame(input bit w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [7:0] div);
    logic [31:0] rd;
    logic [63:0] ef;
    bit ok;
    half_div = div;
    phy_val = d;
    phy_n = 0;
    if (w) bus_write(DATA_A, {16'h0, d});
    bus_write(CMD_A, cmd_word(w, p, r));
    bus_read(CMD_A, rd);
    check(rd[0] == 1'b1, "R1 busy after launch", 64'(rd), 64'(cmd_word(w, p, r)));
    wait_idle(ok);
    check(ok, "R1 busy clears", 64'(ok), 64'd1);
    ef = exp_frame(w, p, r, d);
    if (w) begin
      check(cap_o == ef, "R3 write frame bits (R2 opcode)", cap_o, ef);
      check(cap_oe == '1, "R3 driven throughout", cap_oe, '1);
    end else begin
      check(cap_o[63:18] == ef[63:18], "R2 read header bits", 64'(cap_o[63:18]), 64'(ef[63:18]));
      check(cap_oe == {{46{1'b1}}, 18'h0}, "R4 release in turnaround/data", cap_oe, {{46{1'b1}}, 18'h0});
      bus_read(DATA_A, rd);
      check(rd == {16'h0, d}, "R4 read value in data register", 64'(rd), 64'(d));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi, lo;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    bus_read(CMD_A, rd);
    check(rd == 32'h0, "R9 command reg after reset", 64'(rd), 64'h0);
    bus_read(DATA_A, rd);
    check(rd == 32'h0, "R9 data reg after reset", 64'(rd), 64'h0);
    check(!mdc && !mdio_oe, "R9 mdc/oe idle", {mdc, mdio_oe}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][30], VEC[v][29:25], VEC[v][24:20], VEC[v][19:4], 8'(VEC[v][3:0]));
    end

    // R8 readback of fields and no launch when bit 0 is 0
    bus_write(CMD_A, 32'hFFFF_FFFE);
    bus_read(CMD_A, rd);
    check(rd == 32'h0001_F1F2, "R8 readback, bit0=0 no launch", 64'(rd), 64'h0001_F1F2);
    repeat (20) @(negedge clk);
    check(!mdc && !mdio_oe, "R8 no frame started", {mdc, mdio_oe}, 2'b00);

    // R5 MDC half-period lengths
    half_div = 8'd3;
    phy_n = 0;
    bus_write(CMD_A, cmd_word(1'b0, 5'h03, 5'h04));
    @(posedge mdc);
    hi = 0;
    while (mdc) begin @(posedge clk); #1; hi++; end
    lo = 0;
    while (!mdc) begin @(posedge clk); #1; lo++; end
    check(hi == 3, "R5 high half length", 64'(hi), 64'd3);
    check(lo == 3, "R5 low half length", 64'(lo), 64'd3);
    wait_idle(ok);

    // R5 divider 0 acts as 1
    half_div = 8'd0;
    bus_write(CMD_A, cmd_word(1'b0, 5'h03, 5'h04));
    @(posedge mdc);
    hi = 0;
    while (mdc) begin @(posedge clk); #1; hi++; end
    check(hi == 1, "R5 zero divider acts as one", 64'(hi), 64'd1);
    wait_idle(ok);

    // R6/R7 writes during busy are ignored
    half_div = 8'd2;
    phy_n = 0;
    bus_write(DATA_A, 32'h0000_BEEF);
    bus_write(CMD_A, cmd_word(1'b1, 5'h0A, 5'h05));
    repeat (30) @(negedge clk);
    bus_write(CMD_A, cmd_word(1'b0, 5'h15, 5'h1A));
    bus_write(DATA_A, 32'h0000_1234);
    wait_idle(ok);
    check(cap_o == exp_frame(1'b1, 5'h0A, 5'h05, 16'hBEEF), "R6 frame unaffected",
          cap_o, exp_frame(1'b1, 5'h0A, 5'h05, 16'hBEEF));
    bus_read(CMD_A, rd);
    check(rd == 32'h0000_A052, "R6 fields kept", 64'(rd), 64'h0000_A052);
    bus_read(DATA_A, rd);
    check(rd == 32'h0000_BEEF, "R7 data kept", 64'(rd), 64'h0000_BEEF);
    repeat (40) @(negedge clk);
    check(!mdc && !mdio_oe, "R6 no second frame", {mdc, mdio_oe}, 2'b00);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule